// File: doc/BRIEF.md
# Raster Timing Generator with Phase-Start Events

The block produces horizontal and vertical raster timing for a display pipe. Each line walks through four phases in a fixed order (sync, back porch, active, front porch), each lasting a programmable number of pixel clocks. The frame walks through the same four phases counted in lines. At the first cycle of every phase the block raises a one-cycle strobe. The same happens at the final cycle of the frame and when a single-shot run stops. The strobes also set sticky status bits. An enable mask selects which status bits drive the interrupt output.

Software programs the block through a simple word-addressed write port with a combinational read mux. One control word holds run, repeat and interlace flags. Two words hold the horizontal lengths. Two pairs of words hold the vertical lengths, one pair for odd fields and one for even fields. With the repeat flag set the generator wraps into the next frame. With it clear the generator runs one frame, reports idle and waits until the run flag is cleared.

Top module: `vtg_top`

## Requirements
- R1: After reset all registers read zero, the interrupt is low, and the sync, data-enable and strobe outputs are low.
- R2: Addresses are 0 control, 1 horizontal {back porch[31:16], sync[15:0]}, 2 horizontal {front porch[31:16], active[15:0]}, 3/4 odd-field vertical words with the same packing, 5/6 even-field vertical words, 7 interrupt enable, 8 status. Control bits are run = bit 0, repeat = bit 1, interlace = bit 4. Writes read back.
- R3: Within a line the phases run sync, back porch, active, front porch for their programmed cycle counts. Strobe bits 0 to 3 (sync, back porch, active, front porch) pulse at the first cycle of each phase, and hsync_o is high during the sync phase.
- R4: The vertical phases follow the same order counted in lines. Strobe bits 4 to 7 pulse at the first cycle of the first line of each vertical phase. de_o is high exactly for active pixels of active lines.
- R5: A programmed length of zero behaves as a length of one.
- R6: Strobe bit 8 pulses on the last cycle of every frame. Without repeat, the generator stops after that frame and strobe bit 9 pulses on the next cycle. No further strobes follow while run stays set.
- R7: With repeat set, the cycle after a frame's last cycle starts the next frame at vertical sync.
- R8: With interlace and repeat set, frames alternate odd then even, starting with odd, and each uses its own vertical word pair.
- R9: Status bits stay set until a write to the status address with 1 in that bit position. A new strobe in the same cycle wins over the clear.
- R10: irq_o is high when any status bit is set together with its interrupt enable bit.
- R11: Clearing run mid-frame stops all timing outputs and strobes within two cycles, and no idle strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| hsync_o | output | 1 | High during the horizontal sync phase |
| vsync_o | output | 1 | High during vertical sync lines |
| de_o | output | 1 | High on active pixels of active lines |
| evt_o | output | 10 | One-cycle phase-start strobes |
| irq_o | output | 1 | Masked OR of the sticky status |

## Verification
A scoreboard predicts the cycle offset and bit pattern of every strobe in a frame and compares each observed strobe against it. A design that skipped a zero-length phase, or placed the front-porch strobe apart from the frame-end strobe when both fall on one cycle, would therefore misalign. The bench runs an interlaced repeating sequence in which odd and even fields have different line counts. A design that kept the odd parameters, or failed to wrap at vertical sync, would shift every following strobe. It also checks that a stopped single-shot run stays silent, that an abort raises no idle strobe, and that the status bits clear on write-one and drive the interrupt through the mask.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
    localparam int LEN_W   = 16;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 4;
    localparam int NUM_EVT = 10;
    localparam int NUM_PH  = 4;

    typedef enum logic [1:0] {
        PH_SYNC  = 2'd0,
        PH_BACK  = 2'd1,
        PH_ACT   = 2'd2,
        PH_FRONT = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } run_e;

    // field order puts sync lowest so the struct maps onto [phase] indexing
    typedef struct packed {
        logic [LEN_W-1:0] front;
        logic [LEN_W-1:0] act;
        logic [LEN_W-1:0] back;
        logic [LEN_W-1:0] sync;
    } axis_t;

    typedef struct packed {
        logic intl;
        logic cont;
        logic en;
    } ctrl_t;

    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] A_HSB   = 4'd1;
    localparam logic [ADDR_W-1:0] A_HFA   = 4'd2;
    localparam logic [ADDR_W-1:0] A_VSB_O = 4'd3;
    localparam logic [ADDR_W-1:0] A_VFA_O = 4'd4;
    localparam logic [ADDR_W-1:0] A_VSB_E = 4'd5;
    localparam logic [ADDR_W-1:0] A_VFA_E = 4'd6;
    localparam logic [ADDR_W-1:0] A_IEN   = 4'd7;
    localparam logic [ADDR_W-1:0] A_STAT  = 4'd8;

    localparam int EV_VBASE = 4;
    localparam int EV_FEND  = 8;
    localparam int EV_IDLE  = 9;

    function automatic axis_t unpack_axis(input logic [DATA_W-1:0] sb,
                                          input logic [DATA_W-1:0] fa);
        axis_t a;
        a.sync  = sb[LEN_W-1:0];
        a.back  = sb[DATA_W-1:LEN_W];
        a.act   = fa[LEN_W-1:0];
        a.front = fa[DATA_W-1:LEN_W];
        return a;
    endfunction
endpackage

// File: rtl/vtg_phase_seq.sv
module vtg_phase_seq
    import vtg_pkg::*;
#(
    parameter int W = LEN_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clear,
    input  logic                     step,
    input  logic [NUM_PH-1:0][W-1:0] lens,
    output phase_e                   phase,
    output logic                     first,
    output logic                     last
);
    logic [W-1:0]             cnt;
    logic [NUM_PH-1:0][W-1:0] lim;
    logic                     phase_end;
    logic [1:0]               nxt;

    // zero length counts as one cycle/line
    for (genvar g = 0; g < NUM_PH; g++) begin : g_lim
        assign lim[g] = (lens[g] == '0) ? '0 : lens[g] - W'(1);
    end

    assign phase_end = (cnt >= lim[phase]);
    assign nxt       = phase + 2'd1;
    assign first     = (cnt == '0);
    assign last      = (phase == PH_FRONT) && phase_end;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            phase <= PH_SYNC;
            cnt   <= '0;
        end else if (step) begin
            if (phase_end) begin
                cnt   <= '0;
                phase <= phase_e'(nxt);
            end else begin
                cnt <= cnt + W'(1);
            end
        end
    end
endmodule

// File: rtl/vtg_regs.sv
module vtg_regs
    import vtg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_EVT-1:0] evt,
    output ctrl_t              ctrl,
    output axis_t              h_axis,
    output axis_t              v_odd,
    output axis_t              v_even,
    output logic [NUM_EVT-1:0] inten,
    output logic [NUM_EVT-1:0] status,
    output logic [DATA_W-1:0]  rdata
);
    logic [DATA_W-1:0] hsb_q, hfa_q;
    logic [DATA_W-1:0] vsb_q [2];
    logic [DATA_W-1:0] vfa_q [2];
    logic [NUM_EVT-1:0] clr;

    assign clr = (wr_en && addr == A_STAT) ? wdata[NUM_EVT-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            hsb_q  <= '0;
            hfa_q  <= '0;
            inten  <= '0;
            status <= '0;
            for (int f = 0; f < 2; f++) begin
                vsb_q[f] <= '0;
                vfa_q[f] <= '0;
            end
        end else begin
            if (wr_en) begin
                if (addr == A_CTRL) begin
                    ctrl.en   <= wdata[0];
                    ctrl.cont <= wdata[1];
                    ctrl.intl <= wdata[4];
                end
                if (addr == A_HSB) hsb_q <= wdata;
                if (addr == A_HFA) hfa_q <= wdata;
                if (addr == A_IEN) inten <= wdata[NUM_EVT-1:0];
                for (int f = 0; f < 2; f++) begin
                    if (addr == A_VSB_O + ADDR_W'(2 * f)) vsb_q[f] <= wdata;
                    if (addr == A_VFA_O + ADDR_W'(2 * f)) vfa_q[f] <= wdata;
                end
            end
            status <= (status & ~clr) | evt;
        end
    end

    assign h_axis = unpack_axis(hsb_q, hfa_q);
    assign v_odd  = unpack_axis(vsb_q[0], vfa_q[0]);
    assign v_even = unpack_axis(vsb_q[1], vfa_q[1]);

    always_comb begin
        case (addr)
            A_CTRL:  rdata = {27'b0, ctrl.intl, 2'b0, ctrl.cont, ctrl.en};
            A_HSB:   rdata = hsb_q;
            A_HFA:   rdata = hfa_q;
            A_VSB_O: rdata = vsb_q[0];
            A_VFA_O: rdata = vfa_q[0];
            A_VSB_E: rdata = vsb_q[1];
            A_VFA_E: rdata = vfa_q[1];
            A_IEN:   rdata = {{(DATA_W-NUM_EVT){1'b0}}, inten};
            A_STAT:  rdata = {{(DATA_W-NUM_EVT){1'b0}}, status};
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/vtg_top.sv
module vtg_top
    import vtg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               hsync_o,
    output logic               vsync_o,
    output logic               de_o,
    output logic [NUM_EVT-1:0] evt_o,
    output logic               irq_o
);
    ctrl_t  ctrl;
    axis_t  h_axis, v_odd, v_even, v_axis;
    logic [NUM_EVT-1:0] inten_w, status_w;
    logic [NUM_PH-1:0][LEN_W-1:0] h_lens, v_lens;

    run_e   state;
    logic   field_q, idle_q, run;
    phase_e hph, vph;
    logic   hfirst, hlast, vfirst, vlast;
    logic   line_start, line_end, frame_end;

    vtg_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .evt    (evt_o),
        .ctrl   (ctrl),
        .h_axis (h_axis),
        .v_odd  (v_odd),
        .v_even (v_even),
        .inten  (inten_w),
        .status (status_w),
        .rdata  (rdata)
    );

    assign v_axis = field_q ? v_even : v_odd;
    assign h_lens = h_axis;
    assign v_lens = v_axis;
    assign run    = (state == ST_RUN);

    vtg_phase_seq #(.W(LEN_W)) u_hseq (
        .clk   (clk),
        .rst   (rst),
        .clear (!run),
        .step  (run),
        .lens  (h_lens),
        .phase (hph),
        .first (hfirst),
        .last  (hlast)
    );

    vtg_phase_seq #(.W(LEN_W)) u_vseq (
        .clk   (clk),
        .rst   (rst),
        .clear (!run),
        .step  (line_end),
        .lens  (v_lens),
        .phase (vph),
        .first (vfirst),
        .last  (vlast)
    );

    assign line_start = run && hfirst && (hph == PH_SYNC);
    assign line_end   = run && hlast;
    assign frame_end  = line_end && vlast;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            field_q <= 1'b0;
            idle_q  <= 1'b0;
        end else begin
            idle_q <= 1'b0;
            case (state)
                ST_IDLE: if (ctrl.en) begin
                    state   <= ST_RUN;
                    field_q <= 1'b0;
                end
                ST_RUN: begin
                    if (!ctrl.en) begin
                        state <= ST_IDLE;
                    end else if (frame_end) begin
                        if (ctrl.cont) begin
                            field_q <= ctrl.intl ? ~field_q : 1'b0;
                        end else begin
                            state  <= ST_DONE;
                            idle_q <= 1'b1;
                        end
                    end
                end
                ST_DONE: if (!ctrl.en) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    for (genvar k = 0; k < NUM_PH; k++) begin : g_evt
        assign evt_o[k]          = run && hfirst && (hph == phase_e'(k));
        assign evt_o[EV_VBASE+k] = line_start && vfirst && (vph == phase_e'(k));
    end
    assign evt_o[EV_FEND] = frame_end;
    assign evt_o[EV_IDLE] = idle_q;

    assign hsync_o = run && (hph == PH_SYNC);
    assign vsync_o = run && (vph == PH_SYNC);
    assign de_o    = run && (hph == PH_ACT) && (vph == PH_ACT);
    assign irq_o   = |(status_w & inten_w);
endmodule

// File: rtl/vtg_checker.sv
module vtg_checker
    import vtg_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr,
    input logic               hsync_o,
    input logic               vsync_o,
    input logic               de_o,
    input logic [NUM_EVT-1:0] evt_o,
    input logic               irq_o,
    input logic [NUM_EVT-1:0] status,
    input logic [NUM_EVT-1:0] inten
);
    p_hsync_rise_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(hsync_o) |-> evt_o[0]);

    p_de_rise_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(de_o) |-> evt_o[2]);

    p_vsync_rise_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(vsync_o) |-> (evt_o[4] && evt_o[0]));

    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        evt_o[EV_IDLE] |-> (!hsync_o && !vsync_o && !de_o && evt_o[EV_IDLE-1:0] == '0));

    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == A_STAT) |=> ((status & $past(status)) == $past(status)));

    p_irq_r10: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && |(evt_o & inten)) |=> irq_o);
endmodule

bind vtg_top vtg_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .hsync_o (hsync_o),
    .vsync_o (vsync_o),
    .de_o    (de_o),
    .evt_o   (evt_o),
    .irq_o   (irq_o),
    .status  (status_w),
    .inten   (inten_w)
);

// File: tb/tb_vtg_top.sv
`timescale 1ns/1ps
module tb_vtg_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        hsync_o, vsync_o, de_o, irq_o;
    logic [9:0]  evt_o;

    vtg_top dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
        .evt_o(evt_o), .irq_o(irq_o)
    );

    always #4 clk = ~clk;

    typedef struct { int off; logic [9:0] m; } item_t;
    item_t sb_q[$];

    int total = 0, bad = 0, cyc = 0, base = 0, de_cnt = 0;
    bit base_set = 0, mon_en = 0, done_flag = 0;
    string sb_tag = "R3";

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // monitor: pops the predicted strobes as they appear
    always @(negedge clk) begin
        if (mon_en && !rst) begin
            if (de_o) de_cnt++;
            if (evt_o != '0) begin
                if (!base_set) begin
                    base_set = 1;
                    base = cyc;
                end
                if (sb_q.size() == 0) begin
                    chk(0, sb_tag, "unexpected strobe", {22'b0, evt_o}, 0);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    chk(evt_o == it.m, sb_tag, "strobe bits", {22'b0, evt_o}, {22'b0, it.m});
                    chk(cyc - base == it.off, sb_tag, "strobe offset", cyc - base, it.off);
                end
            end
        end
    end

    function automatic int e1(input int x);
        return (x == 0) ? 1 : x;
    endfunction

    task automatic push(input int off, input logic [9:0] m);
        item_t it;
        it.off = off;
        it.m = m;
        sb_q.push_back(it);
    endtask

    // expected strobes of one frame, offsets relative to the run start
    task automatic gen_frame(input int b, input int hs, input int hb, input int ha,
                             input int hf, input int vs, input int vb, input int va,
                             input int vf, input bit oneshot, output int flen);
        int hS, hB, hA, hF, vS, vB, vA, vF, L, VT, tend;
        hS = e1(hs); hB = e1(hb); hA = e1(ha); hF = e1(hf);
        vS = e1(vs); vB = e1(vb); vA = e1(va); vF = e1(vf);
        L = hS + hB + hA + hF;
        VT = vS + vB + vA + vF;
        tend = b + VT * L - 1;
        for (int l = 0; l < VT; l++) begin
            int t0;
            logic [9:0] m0, m3;
            t0 = b + l * L;
            m0 = 10'h001;
            if (l == 0) m0 |= 10'h010;
            if (l == vS) m0 |= 10'h020;
            if (l == vS + vB) m0 |= 10'h040;
            if (l == vS + vB + vA) m0 |= 10'h080;
            push(t0, m0);
            push(t0 + hS, 10'h002);
            push(t0 + hS + hB, 10'h004);
            m3 = 10'h008;
            if (l == VT - 1 && hF == 1) m3 |= 10'h100;
            push(t0 + hS + hB + hA, m3);
            if (l == VT - 1 && hF > 1) push(tend, 10'h100);
        end
        if (oneshot) push(tend + 1, 10'h200);
        flen = VT * L;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_empty();
        while (sb_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic arm(input string tag);
        base_set = 0; de_cnt = 0; sb_tag = tag; mon_en = 1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] d;
        int fl, fl2;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        rd(4'd8, d); chk(d == 0, "R1", "status after reset", d, 0);
        rd(4'd1, d); chk(d == 0, "R1", "hreg after reset", d, 0);
        chk({irq_o, hsync_o, vsync_o, de_o} == 0, "R1", "outputs after reset",
            {irq_o, hsync_o, vsync_o, de_o}, 0);
        chk(evt_o == 0, "R1", "strobes after reset", evt_o, 0);

        // R2 register map readback
        wr(4'd1, 32'h0002_0003); rd(4'd1, d); chk(d == 32'h0002_0003, "R2", "hreg readback", d, 32'h0002_0003);
        wr(4'd6, 32'hABCD_1234); rd(4'd6, d); chk(d == 32'hABCD_1234, "R2", "even vreg readback", d, 32'hABCD_1234);
        wr(4'd0, 32'hFFFF_FFF2); rd(4'd0, d); chk(d == 32'h12, "R2", "control bits", d, 32'h12);
        wr(4'd0, 32'h0);

        // R3/R4/R6 single frame: h 3,2,4,2  v 2,1,3,1
        wr(4'd1, {16'd2, 16'd3}); wr(4'd2, {16'd2, 16'd4});
        wr(4'd3, {16'd1, 16'd2}); wr(4'd4, {16'd1, 16'd3});
        arm("R3");
        gen_frame(0, 3, 2, 4, 2, 2, 1, 3, 1, 1, fl);
        wr(4'd0, 32'h1);
        wait_empty();
        chk(de_cnt == 12, "R4", "active pixel count", de_cnt, 12);
        rd(4'd8, d); chk(d == 32'h3FF, "R6", "all strobes latched", d, 32'h3FF);
        chk(irq_o == 0, "R10", "irq masked", irq_o, 0);
        wr(4'd7, 32'h200); chk(irq_o == 1, "R10", "irq enabled", irq_o, 1);
        wr(4'd8, 32'h200); chk(irq_o == 0, "R9", "irq after clear", irq_o, 0);
        rd(4'd8, d); chk(d == 32'h1FF, "R9", "only written bit cleared", d, 32'h1FF);
        wr(4'd7, 32'h003); chk(irq_o == 1, "R10", "irq on other mask", irq_o, 1);
        repeat (20) @(negedge clk);
        rd(4'd8, d); chk(d == 32'h1FF, "R6", "no strobes while stopped", d, 32'h1FF);
        chk(sb_q.size() == 0, "R6", "scoreboard drained", sb_q.size(), 0);
        wr(4'd0, 32'h0); wr(4'd7, 32'h0); wr(4'd8, 32'h3FF);
        rd(4'd8, d); chk(d == 0, "R9", "write-one clears all", d, 0);

        // R5 zero lengths: h 0,1,2,0  v 0,0,1,0
        wr(4'd1, {16'd1, 16'd0}); wr(4'd2, {16'd0, 16'd2});
        wr(4'd3, 32'h0); wr(4'd4, {16'd0, 16'd1});
        arm("R5");
        gen_frame(0, 0, 1, 2, 0, 0, 0, 1, 0, 1, fl);
        wr(4'd0, 32'h1);
        wait_empty();
        chk(de_cnt == 2, "R5", "active pixel count", de_cnt, 2);
        wr(4'd0, 32'h0); wr(4'd8, 32'h3FF);

        // R7/R8 interlaced repeat, then one-shot on the even field
        wr(4'd1, {16'd2, 16'd2}); wr(4'd2, {16'd2, 16'd4});
        wr(4'd3, {16'd1, 16'd1}); wr(4'd4, {16'd1, 16'd2});
        wr(4'd5, {16'd1, 16'd2}); wr(4'd6, {16'd2, 16'd1});
        arm("R7");
        gen_frame(0, 2, 2, 4, 2, 1, 1, 2, 1, 0, fl);
        gen_frame(fl, 2, 2, 4, 2, 2, 1, 1, 2, 1, fl2);
        wr(4'd0, 32'h13);
        while (!base_set || (cyc - base) < fl + 5) @(negedge clk);
        wr(4'd0, 32'h11);
        wait_empty();
        chk(de_cnt == 12, "R8", "active pixels over odd+even", de_cnt, 12);
        rd(4'd8, d); chk(d[9:8] == 2'b11, "R6", "frame end and idle latched", d[9:8], 2'b11);
        wr(4'd0, 32'h0); wr(4'd8, 32'h3FF);

        // R11 abort mid-frame
        mon_en = 0;
        wr(4'd0, 32'h1);
        repeat (7) @(negedge clk);
        wr(4'd0, 32'h0);
        @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk({hsync_o, vsync_o, de_o} == 0 && evt_o == 0, "R11", "quiet after abort",
                {19'b0, hsync_o, vsync_o, de_o, evt_o}, 0);
        end
        rd(4'd8, d); chk(d[9] == 0, "R11", "no idle strobe on abort", d[9], 0);

        summary();
    end
endmodule